// File: doc/BRIEF.md
# Coprocessor Register Interface for a Modular-Arithmetic Engine

This block is the bus-facing front end of a modular-arithmetic coprocessor. It is an AXI4-Lite slave whose address space is split into regions by address bits [14:12]. Five of the regions are word stores built inside the block: one for the modulus and four for operands. The other regions are an exponent-FIFO push port and a control register. Bus writes become word writes into the stores or pushes into an external FIFO. The control register is decoded into the selects, the mode bits and a one-cycle start pulse that drive an external arithmetic engine.

The engine reaches the stores through its own combinational read port, which takes a store number and a word index. It writes results back through a write port that targets the operand named in the destination field. When the engine reports completion, the block raises a level interrupt. Bus reads of operand space return the destination operand. When the pipeline select is set to the upper half, reads use a window shifted by half the store depth.

Top module: `mmcop_regif`

## Requirements
- R1: The region is taken from address bits [14:12]: 000 modulus, 001 to 100 operands 0 to 3, 101 FIFO push, 110 control, 111 unmapped. A write to a store region puts the data in word address[7:2] of that store; word 0 holds the least significant 32 bits. A write with address bit 15 set, or to region 111, changes nothing and returns OKAY.
- R2: A bus read from any operand region (001 to 100) returns the word of the operand named by control bits [29:28] (0 to 3), not the word of the addressed region. Read data and RVALID are held until RREADY.
- R3: With control bits [31:30] = 10, operand reads fetch word index address[7:2] + OP_WORDS/2. Any other value uses address[7:2] directly. An index at or beyond OP_WORDS reads as zero.
- R4: The control register fields drive the engine outputs: [31:30] pipeline select, [29:28] destination, [27:26] X select, [25:24] Y select, [22] exponentiation mode, [21] modulus select. A read of region 110 returns bits [31:21] as written and zeros below.
- R5: eng_start pulses high for exactly one cycle when a control write takes bit 23 from 0 to 1. A write that leaves bit 23 at 1 gives no pulse.
- R6: irq goes high the cycle after eng_done is seen and stays high until the next start pulse clears it. A done in the same cycle as a start pulse keeps irq high.
- R7: A write to the FIFO region while fifo_full is low gives one fifo_push cycle carrying the write data. While fifo_full is high the write is dropped and BRESP is 10.
- R8: Reads from the modulus, FIFO and unmapped regions return zero. RRESP is always 00.
- R9: The write-address and write-data channels are taken independently, in either order. BVALID rises only after both have been taken, and BVALID and BRESP hold until BREADY. All writes except R7's dropped push answer 00.
- R10: The engine read port returns word eng_rd_idx of store eng_rd_store, where 0 is the modulus and 1 to 4 are operands 0 to 3. eng_wr_en writes eng_wr_data into word eng_wr_idx of the destination operand. An engine write takes priority over a bus write to the same store in the same cycle.
- R11: After reset, BVALID, RVALID, eng_start, irq and fifo_push are low and every control field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 16 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 16 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_pipe_sel | output | 2 | Pipeline select field |
| eng_dest_sel | output | 2 | Destination operand field |
| eng_x_sel | output | 2 | X operand select field |
| eng_y_sel | output | 2 | Y operand select field |
| eng_exp_mode | output | 1 | Exponentiation mode bit |
| eng_mod_sel | output | 1 | Modulus select bit |
| eng_start | output | 1 | One-cycle start pulse |
| eng_done | input | 1 | Engine completion strobe |
| irq | output | 1 | Completion interrupt level |
| fifo_push | output | 1 | Exponent FIFO push strobe |
| fifo_wdata | output | 32 | Exponent FIFO push data |
| fifo_full | input | 1 | Exponent FIFO full flag |
| eng_rd_store | input | 3 | Engine read store number |
| eng_rd_idx | input | 6 | Engine read word index |
| eng_rd_data | output | 32 | Engine read data |
| eng_wr_en | input | 1 | Engine write enable |
| eng_wr_idx | input | 6 | Engine write word index |
| eng_wr_data | input | 32 | Engine write data |

## Verification
The assertions rely on the bus master following the valid/ready rules. An asserted valid stays up with stable payload until taken, and BREADY and RREADY are the only way to retire a response. They also assume eng_done is a clean synchronous strobe that is low while reset is applied. The bench drives every input on the falling edge. It raises each valid only through its transfer tasks and drops it after the observed handshake. It pulses eng_done for one cycle at a time and keeps it low through reset. Completions are only raised while no control write is in flight.

// File: rtl/mmcop_pkg.sv
package mmcop_pkg;

  localparam logic [2:0] RG_MOD  = 3'd0;
  localparam logic [2:0] RG_OP0  = 3'd1;
  localparam logic [2:0] RG_OP3  = 3'd4;
  localparam logic [2:0] RG_FIFO = 3'd5;
  localparam logic [2:0] RG_CTRL = 3'd6;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  localparam logic [1:0] PIPE_UPPER = 2'b10;

  // Field order matches bits [31:21] of the control word
  typedef struct packed {
    logic [1:0] pipe;
    logic [1:0] dest;
    logic [1:0] xsel;
    logic [1:0] ysel;
    logic       go;
    logic       expo;
    logic       msel;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/mmcop_axil_front.sv
module mmcop_axil_front #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        wr_resp,
  input  logic [DATA_W-1:0] rd_word
);

  logic              aw_got_q, aw_got_d;
  logic              w_got_q, w_got_d;
  logic [ADDR_W-1:0] aw_q, aw_d;
  logic [DATA_W-1:0] w_q, w_d;
  logic              bvalid_q, bvalid_d;
  logic [1:0]        bresp_q, bresp_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              aw_fire, w_fire, ar_fire;

  assign s_awready = !aw_got_q && !bvalid_q;
  assign s_wready  = !w_got_q && !bvalid_q;
  assign s_arready = !rvalid_q;
  assign aw_fire   = s_awvalid && s_awready;
  assign w_fire    = s_wvalid && s_wready;
  assign ar_fire   = s_arvalid && s_arready;
  assign wr_fire   = aw_got_q && w_got_q && !bvalid_q;
  assign wr_addr   = aw_q;
  assign wr_data   = w_q;

  always_comb begin
    aw_d     = aw_fire ? s_awaddr : aw_q;
    w_d      = w_fire ? s_wdata : w_q;
    aw_got_d = wr_fire ? 1'b0 : (aw_got_q || aw_fire);
    w_got_d  = wr_fire ? 1'b0 : (w_got_q || w_fire);
    bvalid_d = wr_fire ? 1'b1 : (bvalid_q && !s_bready);
    bresp_d  = wr_fire ? wr_resp : bresp_q;
    rvalid_d = ar_fire ? 1'b1 : (rvalid_q && !s_rready);
    rdata_d  = ar_fire ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_got_q <= 1'b0;
      w_got_q  <= 1'b0;
      aw_q     <= '0;
      w_q      <= '0;
      bvalid_q <= 1'b0;
      bresp_q  <= 2'b00;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      aw_got_q <= aw_got_d;
      w_got_q  <= w_got_d;
      if (aw_fire) aw_q <= aw_d;
      if (w_fire)  w_q  <= w_d;
      bvalid_q <= bvalid_d;
      if (wr_fire) bresp_q <= bresp_d;
      rvalid_q <= rvalid_d;
      if (ar_fire) rdata_q <= rdata_d;
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_bresp  = bresp_q;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;

  AST_BRESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid_q && !s_bready) |=> (bvalid_q && $stable(bresp_q))); // R9
  AST_B_AFTER_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bvalid_q) |-> $past(aw_got_q && w_got_q)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid_q && !s_rready) |=> (rvalid_q && $stable(rdata_q))); // R2

endmodule

// File: rtl/mmcop_ctrl.sv
module mmcop_ctrl
  import mmcop_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ctrl_we,
  input  ctrl_t ctrl_wval,
  input  logic  eng_done,
  output ctrl_t ctrl,
  output logic  start,
  output logic  irq
);

  ctrl_t ctrl_q;
  logic  start_q, start_d;
  logic  irq_q, irq_d;

  always_comb begin
    start_d = ctrl_we && ctrl_wval.go && !ctrl_q.go;
    if (eng_done)     irq_d = 1'b1;
    else if (start_q) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_wval;
      start_q <= start_d;
      irq_q   <= irq_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign start = start_q;
  assign irq   = irq_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q); // R5
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> irq_q); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !start_q) |=> irq_q); // R6

endmodule

// File: rtl/mmcop_opstore.sv
module mmcop_opstore #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 32,
  parameter int NSTORE = 5,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              bus_we,
  input  logic [2:0]        bus_store,
  input  logic [IDX_W-1:0]  bus_idx,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              eng_we,
  input  logic [2:0]        eng_store,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic [2:0]        ra_store,
  input  logic [IDX_W:0]    ra_idx,
  output logic [DATA_W-1:0] ra_data,
  input  logic [2:0]        rb_store,
  input  logic [IDX_W:0]    rb_idx,
  output logic [DATA_W-1:0] rb_data
);

  localparam int AW = $clog2(WORDS);
  localparam logic [IDX_W-1:0] LIM_W = IDX_W'(WORDS);
  localparam logic [IDX_W:0]   LIM_R = (IDX_W + 1)'(WORDS);

  logic [DATA_W-1:0] rd_a [NSTORE];
  logic [DATA_W-1:0] rd_b [NSTORE];

  for (genvar s = 0; s < NSTORE; s++) begin : g_store
    logic [DATA_W-1:0] mem [WORDS];
    logic              we_s;
    logic [AW-1:0]     wa_s;
    logic [DATA_W-1:0] wd_s;

    always_comb begin
      we_s = 1'b0;
      wa_s = bus_idx[AW-1:0];
      wd_s = bus_wdata;
      if (eng_we && (eng_store == 3'(s)) && (eng_idx < LIM_W)) begin
        we_s = 1'b1;
        wa_s = eng_idx[AW-1:0];
        wd_s = eng_wdata;
      end else if (bus_we && (bus_store == 3'(s)) && (bus_idx < LIM_W)) begin
        we_s = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (we_s) mem[wa_s] <= wd_s;
    end

    assign rd_a[s] = mem[ra_idx[AW-1:0]];
    assign rd_b[s] = mem[rb_idx[AW-1:0]];
  end

  always_comb begin
    ra_data = '0;
    rb_data = '0;
    for (int s = 0; s < NSTORE; s++) begin
      if ((ra_store == 3'(s)) && (ra_idx < LIM_R)) ra_data = rd_a[s];
      if ((rb_store == 3'(s)) && (rb_idx < LIM_R)) rb_data = rd_b[s];
    end
  end

endmodule

// File: rtl/mmcop_regif.sv
module mmcop_regif
  import mmcop_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int OP_WORDS = 32,
  parameter int IDX_W    = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [1:0]        eng_pipe_sel,
  output logic [1:0]        eng_dest_sel,
  output logic [1:0]        eng_x_sel,
  output logic [1:0]        eng_y_sel,
  output logic              eng_exp_mode,
  output logic              eng_mod_sel,
  output logic              eng_start,
  input  logic              eng_done,
  output logic              irq,
  output logic              fifo_push,
  output logic [DATA_W-1:0] fifo_wdata,
  input  logic              fifo_full,
  input  logic [2:0]        eng_rd_store,
  input  logic [IDX_W-1:0]  eng_rd_idx,
  output logic [DATA_W-1:0] eng_rd_data,
  input  logic              eng_wr_en,
  input  logic [IDX_W-1:0]  eng_wr_idx,
  input  logic [DATA_W-1:0] eng_wr_data
);

  localparam int NSTORE   = 5;
  localparam int CTRL_LSB = DATA_W - CTRL_W;
  localparam logic [IDX_W:0] UPPER_OFF = (IDX_W + 1)'(OP_WORDS / 2);

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rsync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_i = rsync_q[1];

  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [1:0]        wr_resp;
  logic [DATA_W-1:0] rd_word;

  mmcop_axil_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_front (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .s_awaddr  (s_awaddr),
    .s_awvalid (s_awvalid),
    .s_awready (s_awready),
    .s_wdata   (s_wdata),
    .s_wvalid  (s_wvalid),
    .s_wready  (s_wready),
    .s_bresp   (s_bresp),
    .s_bvalid  (s_bvalid),
    .s_bready  (s_bready),
    .s_arvalid (s_arvalid),
    .s_arready (s_arready),
    .s_rdata   (s_rdata),
    .s_rvalid  (s_rvalid),
    .s_rready  (s_rready),
    .wr_fire   (wr_fire),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_resp   (wr_resp),
    .rd_word   (rd_word)
  );
  assign s_rresp = RESP_OKAY;

  // Write decode
  logic [2:0] w_region;
  logic       w_mapped, w_store, w_fifo, w_ctrl;

  always_comb begin
    w_region = wr_addr[14:12];
    w_mapped = (wr_addr[ADDR_W-1:15] == '0);
    w_store  = w_mapped && (w_region <= RG_OP3);
    w_fifo   = w_mapped && (w_region == RG_FIFO);
    w_ctrl   = w_mapped && (w_region == RG_CTRL);
    wr_resp  = (w_fifo && fifo_full) ? RESP_SLVERR : RESP_OKAY;
  end

  // Control register, start pulse and interrupt
  ctrl_t ctrl;

  mmcop_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .ctrl_we   (wr_fire && w_ctrl),
    .ctrl_wval (ctrl_t'(wr_data[DATA_W-1:CTRL_LSB])),
    .eng_done  (eng_done),
    .ctrl      (ctrl),
    .start     (eng_start),
    .irq       (irq)
  );

  assign eng_pipe_sel = ctrl.pipe;
  assign eng_dest_sel = ctrl.dest;
  assign eng_x_sel    = ctrl.xsel;
  assign eng_y_sel    = ctrl.ysel;
  assign eng_exp_mode = ctrl.expo;
  assign eng_mod_sel  = ctrl.msel;

  // FIFO push, registered at commit
  logic              push_q, push_d;
  logic [DATA_W-1:0] pdata_q;

  assign push_d = wr_fire && w_fifo && !fifo_full;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      push_q  <= 1'b0;
      pdata_q <= '0;
    end else begin
      push_q <= push_d;
      if (push_d) pdata_q <= wr_data;
    end
  end
  assign fifo_push  = push_q;
  assign fifo_wdata = pdata_q;

  // Read decode
  logic [2:0]        r_region;
  logic              r_mapped;
  logic [IDX_W:0]    r_idx;
  logic [2:0]        dest_store;
  logic [DATA_W-1:0] bus_rd;

  always_comb begin
    r_region   = s_araddr[14:12];
    r_mapped   = (s_araddr[ADDR_W-1:15] == '0);
    r_idx      = {1'b0, s_araddr[IDX_W+1:2]}
               + ((ctrl.pipe == PIPE_UPPER) ? UPPER_OFF : '0);
    dest_store = {1'b0, ctrl.dest} + 3'd1;
    rd_word    = '0;
    if (r_mapped) begin
      if ((r_region >= RG_OP0) && (r_region <= RG_OP3)) rd_word = bus_rd;
      else if (r_region == RG_CTRL) rd_word = {ctrl, {CTRL_LSB{1'b0}}};
    end
  end

  mmcop_opstore #(
    .DATA_W (DATA_W),
    .WORDS  (OP_WORDS),
    .NSTORE (NSTORE),
    .IDX_W  (IDX_W)
  ) u_store (
    .clk       (clk),
    .bus_we    (wr_fire && w_store),
    .bus_store (w_region),
    .bus_idx   (wr_addr[IDX_W+1:2]),
    .bus_wdata (wr_data),
    .eng_we    (eng_wr_en),
    .eng_store (dest_store),
    .eng_idx   (eng_wr_idx),
    .eng_wdata (eng_wr_data),
    .ra_store  (dest_store),
    .ra_idx    (r_idx),
    .ra_data   (bus_rd),
    .rb_store  (eng_rd_store),
    .rb_idx    ({1'b0, eng_rd_idx}),
    .rb_data   (eng_rd_data)
  );

  logic unused_addr_bits;
  assign unused_addr_bits = ^{wr_addr[11:IDX_W+2], wr_addr[1:0],
                              s_araddr[11:IDX_W+2], s_araddr[1:0]};

  AST_PUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_i)
    push_q |=> !push_q); // R7
  AST_RESP_OKAY_CTRL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_fire && !w_fifo) |=> (s_bvalid && (s_bresp == RESP_OKAY))); // R9

endmodule

// File: tb/mmcop_regif_bench.sv
`timescale 1ns/1ps
module mmcop_regif_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] s_awaddr;
  logic        s_awvalid;
  logic        s_awready;
  logic [31:0] s_wdata;
  logic        s_wvalid;
  logic        s_wready;
  logic [1:0]  s_bresp;
  logic        s_bvalid;
  logic        s_bready;
  logic [15:0] s_araddr;
  logic        s_arvalid;
  logic        s_arready;
  logic [31:0] s_rdata;
  logic [1:0]  s_rresp;
  logic        s_rvalid;
  logic        s_rready;
  logic [1:0]  eng_pipe_sel, eng_dest_sel, eng_x_sel, eng_y_sel;
  logic        eng_exp_mode, eng_mod_sel, eng_start, eng_done, irq;
  logic        fifo_push;
  logic [31:0] fifo_wdata;
  logic        fifo_full;
  logic [2:0]  eng_rd_store;
  logic [5:0]  eng_rd_idx;
  logic [31:0] eng_rd_data;
  logic        eng_wr_en;
  logic [5:0]  eng_wr_idx;
  logic [31:0] eng_wr_data;

  always #2.5 clk = ~clk;

  mmcop_regif u_mmcop_regif (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bresp(s_bresp), .s_bvalid(s_bvalid), .s_bready(s_bready),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rvalid(s_rvalid), .s_rready(s_rready),
    .eng_pipe_sel(eng_pipe_sel), .eng_dest_sel(eng_dest_sel),
    .eng_x_sel(eng_x_sel), .eng_y_sel(eng_y_sel),
    .eng_exp_mode(eng_exp_mode), .eng_mod_sel(eng_mod_sel),
    .eng_start(eng_start), .eng_done(eng_done), .irq(irq),
    .fifo_push(fifo_push), .fifo_wdata(fifo_wdata), .fifo_full(fifo_full),
    .eng_rd_store(eng_rd_store), .eng_rd_idx(eng_rd_idx), .eng_rd_data(eng_rd_data),
    .eng_wr_en(eng_wr_en), .eng_wr_idx(eng_wr_idx), .eng_wr_data(eng_wr_data)
  );

  int tests = 0;
  int fails = 0;
  int start_cnt = 0;
  int push_cnt = 0;
  logic [31:0] push_last = '0;

  always @(posedge clk) begin
    if (eng_start) start_cnt++;
    if (fifo_push) begin
      push_cnt++;
      push_last = fifo_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] adr(input logic [2:0] rg, input logic [5:0] idx);
    return {1'b0, rg, 4'b0000, idx, 2'b00};
  endfunction

  function automatic logic [31:0] cword(input logic [1:0] p, d, x, y,
                                        input logic go, ex, ms);
    return {p, d, x, y, go, ex, ms, 21'b0};
  endfunction

  // order: 0 both together, 1 address first, 2 data first
  task automatic bus_write(input logic [15:0] a, input logic [31:0] d,
                           input int order, output logic [1:0] resp);
    bit aw_done = 0, w_done = 0, early = 0, aw_hit, w_hit;
    s_awaddr = a;
    s_wdata  = d;
    while (!(aw_done && w_done)) begin
      @(negedge clk);
      if (s_bvalid) early = 1;
      s_awvalid = !aw_done && (order != 2 || w_done);
      s_wvalid  = !w_done && (order != 1 || aw_done);
      aw_hit = s_awvalid && s_awready;
      w_hit  = s_wvalid && s_wready;
      @(posedge clk);
      if (aw_hit) aw_done = 1;
      if (w_hit)  w_done = 1;
    end
    @(negedge clk);
    s_awvalid = 0;
    s_wvalid  = 0;
    while (!s_bvalid) @(negedge clk);
    resp = s_bresp;
    if (early) check("R9 bvalid before both channels", 32'(early), 32'd0);
    @(negedge clk);
    if (!s_bvalid || s_bresp !== resp) check("R9 response hold", {30'd0, s_bresp}, {30'd0, resp});
    s_bready = 1;
    @(posedge clk);
    @(negedge clk);
    s_bready = 0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr  = a;
    s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    if (s_rresp !== 2'b00) check("R8 rresp", {30'd0, s_rresp}, 32'd0);
    s_rready = 1;
    @(posedge clk);
    @(negedge clk);
    s_rready = 0;
  endtask

  task automatic eng_peek(input logic [2:0] st, input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk);
    eng_rd_store = st;
    eng_rd_idx   = idx;
    #1;
    d = eng_rd_data;
  endtask

  task automatic wr_ok(input logic [15:0] a, input logic [31:0] d, input string req);
    logic [1:0] r;
    bus_write(a, d, 0, r);
    check(req, {30'd0, r}, 32'd0);
  endtask

  task automatic t_reset;
    check("R11 bvalid", {31'd0, s_bvalid}, 0);
    check("R11 rvalid", {31'd0, s_rvalid}, 0);
    check("R11 irq/start/push", {29'd0, irq, eng_start, fifo_push}, 0);
    check("R11 control fields",
          {22'd0, eng_pipe_sel, eng_dest_sel, eng_x_sel, eng_y_sel, eng_exp_mode, eng_mod_sel}, 0);
  endtask

  task automatic t_store_and_dest;
    logic [31:0] d;
    wr_ok(adr(3'd6, 0), cword(2'b11, 2'b00, 0, 0, 0, 0, 0), "R9 ctrl okay");
    for (int k = 0; k < 4; k++) wr_ok(adr(3'd1, 6'(k)), 32'hA000_0000 + 32'(k), "R1 op0 write");
    wr_ok(adr(3'd2, 0), 32'hB1B1_0000, "R1 op1 write");
    wr_ok(adr(3'd0, 3), 32'hC0DE_0003, "R1 modulus write");
    for (int k = 0; k < 4; k++) begin
      eng_peek(3'd1, 6'(k), d);
      check("R10 engine read op0", d, 32'hA000_0000 + 32'(k));
    end
    eng_peek(3'd0, 3, d);
    check("R10 engine read modulus", d, 32'hC0DE_0003);
    bus_read(adr(3'd1, 2), d);
    check("R2 read op0 word2", d, 32'hA000_0002);
    bus_read(adr(3'd2, 0), d);
    check("R2 op1 region returns dest op0", d, 32'hA000_0000);
    wr_ok(adr(3'd6, 0), cword(2'b11, 2'b01, 0, 0, 0, 0, 0), "R9 ctrl okay");
    bus_read(adr(3'd1, 0), d);
    check("R2 op0 region returns dest op1", d, 32'hB1B1_0000);
    bus_read(adr(3'd0, 3), d);
    check("R8 modulus read zero", d, 0);
    bus_read(adr(3'd7, 0), d);
    check("R8 unmapped read zero", d, 0);
  endtask

  task automatic t_upper_window;
    logic [31:0] d;
    wr_ok(adr(3'd3, 16), 32'h1616_1616, "R1 op2 word16");
    wr_ok(adr(3'd3, 0),  32'h0000_0F0F, "R1 op2 word0");
    wr_ok(adr(3'd6, 0), cword(2'b10, 2'b10, 0, 0, 0, 0, 0), "R9 ctrl okay");
    bus_read(adr(3'd3, 0), d);
    check("R3 upper window word0 -> 16", d, 32'h1616_1616);
    bus_read(adr(3'd3, 20), d);
    check("R3 upper window past depth", d, 0);
    wr_ok(adr(3'd6, 0), cword(2'b01, 2'b10, 0, 0, 0, 0, 0), "R9 ctrl okay");
    bus_read(adr(3'd3, 0), d);
    check("R3 lower window word0", d, 32'h0000_0F0F);
  endtask

  task automatic t_ctrl_fields;
    logic [31:0] d, w;
    w = cword(2'b01, 2'b11, 2'b10, 2'b01, 0, 1, 1);
    wr_ok(adr(3'd6, 0), w, "R9 ctrl okay");
    check("R4 field outputs",
          {22'd0, eng_pipe_sel, eng_dest_sel, eng_x_sel, eng_y_sel, eng_exp_mode, eng_mod_sel},
          {22'd0, 2'b01, 2'b11, 2'b10, 2'b01, 1'b1, 1'b1});
    bus_read(adr(3'd6, 0), d);
    check("R4 control readback", d, w);
  endtask

  task automatic t_start_pulse;
    int c0;
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 0, 0, 0), "R9 ctrl okay");
    c0 = start_cnt;
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 1, 0, 0), "R9 ctrl okay");
    check("R5 one pulse on rise", 32'(start_cnt - c0), 1);
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 1, 0, 0), "R9 ctrl okay");
    check("R5 no pulse while held", 32'(start_cnt - c0), 1);
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 0, 0, 0), "R9 ctrl okay");
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 1, 0, 0), "R9 ctrl okay");
    check("R5 second rise pulses again", 32'(start_cnt - c0), 2);
  endtask

  task automatic t_irq;
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 0, 0, 0), "R9 ctrl okay");
    @(negedge clk);
    eng_done = 1;
    @(negedge clk);
    eng_done = 0;
    check("R6 irq after done", {31'd0, irq}, 1);
    repeat (3) @(negedge clk);
    check("R6 irq held", {31'd0, irq}, 1);
    wr_ok(adr(3'd6, 0), cword(2'b11, 0, 0, 0, 1, 0, 0), "R9 ctrl okay");
    check("R6 irq cleared by start", {31'd0, irq}, 0);
  endtask

  task automatic t_fifo;
    logic [1:0] r;
    logic [31:0] d;
    int p0;
    p0 = push_cnt;
    wr_ok(adr(3'd5, 0), 32'h5EED_0001, "R7 fifo push okay");
    check("R7 one push", 32'(push_cnt - p0), 1);
    check("R7 push data", push_last, 32'h5EED_0001);
    fifo_full = 1;
    bus_write(adr(3'd5, 0), 32'hDEAD_0002, 0, r);
    check("R7 full gives SLVERR", {30'd0, r}, 32'd2);
    check("R7 full no push", 32'(push_cnt - p0), 1);
    fifo_full = 0;
    bus_read(adr(3'd5, 0), d);
    check("R8 fifo read zero", d, 0);
  endtask

  task automatic t_channel_order;
    logic [1:0] r;
    logic [31:0] d;
    bus_write(adr(3'd4, 1), 32'h0A0A_0001, 1, r);
    check("R9 addr first okay", {30'd0, r}, 0);
    bus_write(adr(3'd4, 2), 32'h0D0D_0002, 2, r);
    check("R9 data first okay", {30'd0, r}, 0);
    eng_peek(3'd4, 1, d);
    check("R9 addr-first data landed", d, 32'h0A0A_0001);
    eng_peek(3'd4, 2, d);
    check("R9 data-first data landed", d, 32'h0D0D_0002);
  endtask

  task automatic t_bit15_ignored;
    logic [1:0] r;
    logic [31:0] d;
    bus_write(16'h8000 | adr(3'd2, 0), 32'hBAD0_BAD0, 0, r);
    check("R1 bit15 write okay", {30'd0, r}, 0);
    eng_peek(3'd2, 0, d);
    check("R1 bit15 write ignored", d, 32'hB1B1_0000);
  endtask

  task automatic t_engine_write;
    logic [31:0] d;
    wr_ok(adr(3'd6, 0), cword(2'b11, 2'b11, 0, 0, 0, 0, 0), "R9 ctrl okay");
    @(negedge clk);
    eng_wr_en = 1; eng_wr_idx = 5; eng_wr_data = 32'hE5E5_0005;
    @(negedge clk);
    eng_wr_en = 0;
    bus_read(adr(3'd1, 5), d);
    check("R10 engine write to dest op3", d, 32'hE5E5_0005);
  endtask

  initial begin
    #750000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    s_awaddr = 0; s_awvalid = 0; s_wdata = 0; s_wvalid = 0; s_bready = 0;
    s_araddr = 0; s_arvalid = 0; s_rready = 0;
    eng_done = 0; fifo_full = 0; eng_rd_store = 0; eng_rd_idx = 0;
    eng_wr_en = 0; eng_wr_idx = 0; eng_wr_data = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset;
    t_store_and_dest;
    t_upper_window;
    t_ctrl_fields;
    t_start_pulse;
    t_irq;
    t_fifo;
    t_channel_order;
    t_bit15_ignored;
    t_engine_write;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule